// File: doc/BRIEF.md
# Port Input Deglitch Bank

A bank of per-pin digital input filters for one port of general-purpose pins. Each pin's raw level is first synchronized into the local clock domain. When the pin's filter is switched on, a change on the pin only reaches the output after the new level has held for longer than a programmable number of filter clock periods. Shorter pulses are discarded. The cleaned levels feed the pin-change detection and the input data path downstream.

All pins share one width setting and one filter time base. The time base is either every cycle of the bus clock or a slow low-power tick, nominally 1 kHz. That tick is generated elsewhere and arrives as a one-cycle enable. Each pin has its own enable bit. A pin whose filter is off passes its synchronized level straight on.

Top module: `pin_deglitch_bank`

## Requirements
- R1: While `rstN` is low, every bit of `pinOut` is 0 and every filter count is cleared, whatever `pinRaw` carries.
- R2: Every path from `pinRaw` to `pinOut` passes two synchronizer flops and one output flop. A level on `pinRaw` that is sampled at clock edge k can first appear on `pinOut` after edge k+2.
- R3: With the filter on, a synchronized pulse that lasts at most `glitchLen` filter periods leaves `pinOut` unchanged.
- R4: With the filter on, a synchronized level that lasts `glitchLen`+1 filter periods or more is passed on. On the bus time base it appears `glitchLen` cycles later than an unfiltered pin would show it, and it keeps its duration.
- R5: `glitchLen` is 5 bits wide, so it covers 0 to 31. A value of 0 lets a one-period pulse through. A value of 31 blocks a 31-cycle pulse and passes a 32-cycle pulse.
- R6: Bit n of `filterEn` acts on pin n only. Pins with and without filtering coexist on the same port.
- R7: When bit n of `filterEn` is 0, `pinOut[n]` follows the synchronized level with the R2 latency, whatever `glitchLen` and the time base are set to.
- R8: When `slowSel` is 1, filter counts advance only on cycles in which `slowTick` is 1. When `slowSel` is 0, they advance on every clock cycle.
- R9: Turning a pin's filter off loads that pin's output from its synchronized level and clears its count. After the filter is turned back on, a pulse of at most `glitchLen` periods is still blocked.
- R10: `slowSel` and `glitchLen` are shared by the whole port. A single setting changes the behaviour of every filtered pin at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| pinRaw | input | NUM_PINS | Raw, asynchronous pin levels |
| filterEn | input | NUM_PINS | Per-pin filter enable, bit n for pin n |
| slowSel | input | 1 | Time base select: 0 = bus clock, 1 = slow tick |
| slowTick | input | 1 | One-cycle slow time base enable |
| glitchLen | input | WIDTH_BITS | Longest pulse, in filter periods, that is removed |
| pinOut | output | NUM_PINS | Filtered or synchronized pin levels |

## Verification
Two things can land on the same clock edge. One pin can lose its filter enable while its count is still climbing, and in that same cycle a neighbouring filtered pin is still counting the same pulse. The bench provokes this by raising every pin together and then dropping one pin's enable part way into the count. It judges the result from the outputs alone: the pin that was switched off must copy its input on the next cycle, the neighbour must keep to its own rise cycle, and a short return pulse must afterwards be blocked on both pins. The sweeps also apply each pulse to a mixed mask of filtered and unfiltered pins in the same cycle, and in slow mode the end of the pulse is placed against the tick phase. For every pin, the expected first-rise cycle and high time are computed arithmetically.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
  // strobes issued by the control section to every filter cell
  typedef struct packed {
    logic advance;   // one filter period elapses in this cycle
    logic slowMode;  // time base is the slow tick
  } filt_ctrl_t;
endpackage

// File: rtl/deglitch_ctrl.sv
module deglitch_ctrl
  import deglitch_pkg::*;
(
  input  logic       slowSel,
  input  logic       slowTick,
  output filt_ctrl_t ctrl
);
  always_comb begin
    ctrl.slowMode = slowSel;
    ctrl.advance  = slowSel ? slowTick : 1'b1;
  end
endmodule

// File: rtl/deglitch_cell.sv
module deglitch_cell #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             enable,
  input  logic             advance,
  input  logic [CNT_W-1:0] width,
  output logic             q
);
  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q      <= 1'b0;
      runLen <= '0;
    end else if (!enable) begin
      q      <= syncIn;
      runLen <= '0;
    end else if (syncIn == q) begin
      runLen <= '0;
    end else if (advance) begin
      if (runLen == width) begin
        q      <= syncIn;
        runLen <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/deglitch_datapath.sv
module deglitch_datapath
  import deglitch_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic [NUM_PINS-1:0] filterEn,
  input  logic [CNT_W-1:0]    width,
  input  filt_ctrl_t          ctrl,
  output logic [NUM_PINS-1:0] pinOut
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinRaw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    deglitch_cell #(.CNT_W(CNT_W)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .syncIn  (syncQ[LAST_STAGE][n]),
      .enable  (filterEn[n]),
      .advance (ctrl.advance),
      .width   (width),
      .q       (pinOut[n])
    );
  end
endmodule

// File: rtl/pin_deglitch_bank.sv
module pin_deglitch_bank
  import deglitch_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int WIDTH_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinRaw,
  input  logic [NUM_PINS-1:0]   filterEn,
  input  logic                  slowSel,
  input  logic                  slowTick,
  input  logic [WIDTH_BITS-1:0] glitchLen,
  output logic [NUM_PINS-1:0]   pinOut
);
  filt_ctrl_t ctrl;

  deglitch_ctrl u_ctrl (
    .slowSel  (slowSel),
    .slowTick (slowTick),
    .ctrl     (ctrl)
  );

  deglitch_datapath #(
    .NUM_PINS    (NUM_PINS),
    .CNT_W       (WIDTH_BITS),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinRaw   (pinRaw),
    .filterEn (filterEn),
    .width    (glitchLen),
    .ctrl     (ctrl),
    .pinOut   (pinOut)
  );
endmodule

// File: rtl/deglitch_checker.sv
module deglitch_checker #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinRaw,
  input logic [NUM_PINS-1:0] filterEn,
  input logic                slowSel,
  input logic                slowTick,
  input logic [NUM_PINS-1:0] pinOut
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R1: outputs never go unknown once out of reset
  p_out_known_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(pinOut));

  // R2: any change on an output carries the level sampled three edges back
  p_change_from_input_r2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |->
      (((pinOut ^ $past(pinOut)) & (pinOut ^ $past(pinRaw, 3))) == '0));

  // R7: an unfiltered pin mirrors its synchronized input
  p_bypass_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |->
      (((pinOut ^ $past(pinRaw, 3)) & ~$past(filterEn)) == '0));

  // R8: on the slow time base, filtered pins hold between ticks
  p_slow_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && slowSel && !slowTick) |=>
      (((pinOut ^ $past(pinOut)) & $past(filterEn)) == '0));
endmodule

bind pin_deglitch_bank deglitch_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pinRaw   (pinRaw),
  .filterEn (filterEn),
  .slowSel  (slowSel),
  .slowTick (slowTick),
  .pinOut   (pinOut)
);

// File: tb/sim_pin_deglitch_bank.sv
module sim_pin_deglitch_bank;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinRaw = '0;
  logic [NP-1:0] filterEn = '0;
  logic          slowSel = 1'b0;
  logic          slowTick = 1'b0;
  logic [4:0]    glitchLen = '0;
  logic [NP-1:0] pinOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  pin_deglitch_bank u0 (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .filterEn(filterEn),
    .slowSel(slowSel), .slowTick(slowTick), .glitchLen(glitchLen),
    .pinOut(pinOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit tickAt(input bit slow, input int k);
    return slow ? (k % 4 == 0) : 1'b1;
  endfunction

  // expected first-rise edge (0 = none) and high time, from the requirements
  task automatic expect_pulse(input int w, input int p, input bit slow,
                              output int rise, output int high);
    int n = 0;
    int m = 0;
    rise = 0;
    high = 0;
    for (int k = 3; k <= p + 2; k++) begin
      n += int'(tickAt(slow, k));
      if (n == w + 1) begin rise = k; break; end
    end
    if (rise != 0) begin
      for (int k = p + 3; k < p + 200; k++) begin
        m += int'(tickAt(slow, k));
        if (m == w + 1) begin high = k - rise; break; end
      end
    end
  endtask

  task automatic run_pulse(input int w, input int p, input logic [NP-1:0] en,
                           input bit slow, input string req);
    int firstRise [NP];
    int highCnt [NP];
    int nEdges;
    int er, eh, dr, dh;
    bit bad;
    glitchLen = 5'(w);
    slowSel = slow;
    filterEn = en;
    pinRaw = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) begin firstRise[i] = 0; highCnt[i] = 0; end
    nEdges = p + 12 + 4 * (w + 1);
    for (int k = 1; k <= nEdges; k++) begin
      pinRaw = (k <= p) ? '1 : '0;
      slowTick = (k % 4 == 0);
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        if (pinOut[i]) begin
          highCnt[i]++;
          if (firstRise[i] == 0) firstRise[i] = k;
        end
      end
    end
    slowTick = 1'b0;
    expect_pulse(w, p, slow, er, eh);
    expect_pulse(0, p, 1'b0, dr, dh);
    bad = 0;
    for (int i = 0; i < NP && !bad; i++) begin
      int xr = en[i] ? er : dr;
      int xh = en[i] ? eh : dh;
      if (firstRise[i] != xr || highCnt[i] != xh) begin
        bad = 1;
        $display("FAIL %s w=%0d p=%0d slow=%0d pin=%0d: act rise=%0d high=%0d exp rise=%0d high=%0d",
                 req, w, p, slow, i, firstRise[i], highCnt[i], xr, xh);
      end
    end
    nChecks++;
    if (bad) nFails++;
  endtask

  initial begin
    logic [NP-1:0] pat = 32'hC3A5_96E1;
    // R1: reset holds outputs low even with inputs high
    pinRaw = '1;
    filterEn = '1;
    repeat (5) @(negedge clk);
    check("R1 reset outputs", int'(pinOut), 0);
    pinRaw = '0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", int'(pinOut), 0);

    // R3 R4 R5 R6 R7: bus time base sweep, mixed enable masks
    for (int w = 0; w < 8; w++) begin
      logic [NP-1:0] en = (pat << w) | (pat >> (NP - w));
      for (int p = 1; p <= 10; p++)
        run_pulse(w, p, en, 1'b0, (p > w) ? "R4 pass" : "R3 block");
    end
    // R5: widest setting
    run_pulse(31, 31, '1, 1'b0, "R5 w31 block");
    run_pulse(31, 32, '1, 1'b0, "R5 w31 pass");
    run_pulse(31, 32, '0, 1'b0, "R7 bypass ignores width");

    // R8 R10: slow time base on all filtered pins
    for (int w = 0; w < 4; w++) begin
      run_pulse(w, 1, pat, 1'b1, "R8 slow");
      run_pulse(w, 3, pat, 1'b1, "R8 slow");
      run_pulse(w, 6, pat, 1'b1, "R8 slow");
      run_pulse(w, 9, pat, 1'b1, "R8 slow");
      run_pulse(w, 14, pat, 1'b1, "R10 shared base");
    end

    // R9: drop pin 0's enable during a count, neighbour keeps counting
    glitchLen = 5'd4;
    slowSel = 1'b0;
    filterEn = '1;
    pinRaw = '0;
    repeat (3) @(negedge clk);
    pinRaw = '1;
    repeat (4) @(negedge clk);
    filterEn = ~32'h1;
    @(negedge clk);
    check("R9 disabled pin loads input", int'(pinOut[0]), 1);
    check("R9 neighbour still counting", int'(pinOut[1]), 0);
    filterEn = '1;
    @(negedge clk);
    @(negedge clk);
    check("R4 neighbour rises on schedule", int'(pinOut[1]), 1);
    pinRaw = '0;
    repeat (4) @(negedge clk);
    pinRaw = '1;
    begin
      int lowSeen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!pinOut[0] || !pinOut[1]) lowSeen++;
      end
      check("R9 short low pulse blocked after re-enable", lowSeen, 0);
    end
    pinRaw = '0;
    repeat (20) @(negedge clk);
    check("R3 settles low", int'(pinOut), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule